// File: doc/BRIEF.md
# Video Memory Byte Read Port with Prefetch

This block gives a processor a byte-wide read path into a 16-bit-wide video memory of 32K words. Software loads a word address and a small control register, then reads the memory one byte at a time through two read strobes: one for the low byte and one for the high byte. The port keeps one prefetched byte. Each read hands back the byte fetched by the read before it, then starts a fetch of the selected byte at the current word address. This prefetch matches the way the memory is read, so the first read after an address change returns stale data and software discards it.

The word address steps forward by a programmable amount after a read. A control bit selects whether the low-byte read or the high-byte read causes the step. This lets software walk through either one byte lane or both lanes of consecutive words. The memory side is a synchronous byte-addressed RAM port with one cycle of read latency. The port hides that latency, so the strobes can arrive on back-to-back cycles.

Top module: `vram_rd_port`

## Requirements
- R1: After reset the prefetch byte is 0x00, the word address is 0 and the control register is 0 (step 1, advance on the low read). `rd_valid` is low, `rd_data` is 0x00 and `mem_rd_en` is low. The first read after reset returns 0x00.
- R2: A low-byte read (`rd_lo`) returns the prefetched byte. It reloads the prefetch from byte address {word address, 0}, which is presented on `mem_addr` with `mem_rd_en` in the strobe cycle.
- R3: A high-byte read (`rd_hi` without `rd_lo`) returns the prefetched byte. It reloads the prefetch from byte address {word address, 1}.
- R4: With control bit 7 at 0, the word address advances after a low-byte read only. With bit 7 at 1, it advances after a high-byte read only. Without a read or an address write, the address holds.
- R5: Control bits 1:0 set the step. 0 gives 1, 1 gives 32, and 2 and 3 both give 128.
- R6: The word address is 15 bits wide and wraps modulo 0x8000 when it advances.
- R7: Control bits 3:2 are stored but have no effect on addressing. Bits 6:4 are ignored.
- R8: A read in the same cycle as an address write fetches from the newly written address and then advances from it.
- R9: Reads on consecutive cycles each return the byte fetched by the read just before them.
- R10: When `rd_lo` and `rd_hi` are high together, the port performs a low-byte read only.
- R11: The returned byte appears on `rd_data` in the cycle after the strobe, with `rd_valid` high for exactly that one cycle. `mem_rd_en` is high only in a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load word address |
| addr_wr_data | input | 15 | New word address |
| ctrl_wr | input | 1 | Load control register |
| ctrl_wr_data | input | 8 | Control: bit 7 advance select, bits 3:2 remap field, bits 1:0 step select |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| mem_rd_en | output | 1 | RAM read request |
| mem_addr | output | 16 | RAM byte address |
| mem_rdata | input | 8 | RAM read data, one cycle after request |

## Verification
The bench uses the default parameters: a 15-bit word address and steps of 1, 32 and 128. With these values the address can be loaded just below 0x7FFF, so the wrap to low addresses occurs within one or two reads at either step size. The remaining steps come from the control encodings, which the bench covers one by one. In every strobe cycle the bench compares the memory byte address against its own model. This makes address movement visible at the ports, even where returned bytes alone could not show it.

// File: rtl/vram_rd_pkg.sv
package vram_rd_pkg;

    // Control register fields as stored (bit 7, bits 3:2, bits 1:0 of the written byte)
    typedef struct packed {
        logic       adv_on_hi;
        logic [1:0] remap;
        logic [1:0] step_sel;
    } vrd_ctrl_t;

    localparam int CTRL_BYTE_W  = 8;
    localparam int CTRL_ADV_BIT = 7;

    function automatic vrd_ctrl_t unpack_ctrl(input logic [CTRL_BYTE_W-1:0] raw);
        vrd_ctrl_t c;
        c.adv_on_hi = raw[CTRL_ADV_BIT];
        c.remap     = raw[3:2];
        c.step_sel  = raw[1:0];
        return c;
    endfunction

endpackage

// File: rtl/vram_rd_step.sv
module vram_rd_step #(
    parameter int ADDR_W   = 15,
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic [1:0]        step_sel,
    output logic [ADDR_W-1:0] step
);
    localparam logic [ADDR_W-1:0] STEP_ONE_C = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_MID_C = ADDR_W'(STEP_MID);
    localparam logic [ADDR_W-1:0] STEP_BIG_C = ADDR_W'(STEP_BIG);

    always_comb begin
        unique case (step_sel)
            2'd0:    step = STEP_ONE_C;
            2'd1:    step = STEP_MID_C;
            default: step = STEP_BIG_C;
        endcase
    end
endmodule

// File: rtl/vram_rd_prefetch.sv
module vram_rd_prefetch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] pbuf;
        logic              pending;
        logic [DATA_W-1:0] out;
        logic              valid;
    } pf_state_t;

    pf_state_t st_d, st_q;
    logic [DATA_W-1:0] cur_byte;

    always_comb begin
        // a fetch still landing from the RAM is the freshest prefetch
        cur_byte     = st_q.pending ? mem_rdata : st_q.pbuf;
        st_d         = st_q;
        st_d.pbuf    = cur_byte;
        st_d.pending = fetch;
        st_d.valid   = fetch;
        if (fetch) st_d.out = cur_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.out;
    assign rd_valid = st_q.valid;

    assert_buf_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |=> (st_q.pbuf == $past(mem_rdata)));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> rd_valid);

    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> !rd_valid);
endmodule

// File: rtl/vram_rd_port.sv
module vram_rd_port
    import vram_rd_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wr_data,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wr_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_rd_en,
    output logic [ADDR_W:0]   mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] waddr;
        vrd_ctrl_t         ctrl;
    } port_state_t;

    port_state_t       st_d, st_q;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] eff_addr;
    logic              fetch;
    logic              sel_hi;
    logic              advance;
    logic              unused_bits;

    vram_rd_step #(
        .ADDR_W  (ADDR_W),
        .STEP_MID(STEP_MID),
        .STEP_BIG(STEP_BIG)
    ) i_step (
        .step_sel(st_q.ctrl.step_sel),
        .step    (step)
    );

    always_comb begin
        fetch    = rd_lo | rd_hi;
        sel_hi   = rd_hi & ~rd_lo;
        eff_addr = addr_wr ? addr_wr_data : st_q.waddr;
        advance  = fetch & (sel_hi == st_q.ctrl.adv_on_hi);

        st_d       = st_q;
        st_d.waddr = advance ? (eff_addr + step) : eff_addr;
        if (ctrl_wr) st_d.ctrl = unpack_ctrl(ctrl_wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rd_en   = fetch;
    assign mem_addr    = {eff_addr, sel_hi};
    assign unused_bits = ^{ctrl_wr_data[6:4], st_q.ctrl.remap};

    vram_rd_prefetch #(
        .DATA_W(DATA_W)
    ) i_prefetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch    (fetch),
        .mem_rdata(mem_rdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !rd_hi && !addr_wr) |=> $stable(st_q.waddr));

    assert_new_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && mem_rd_en) |-> (mem_addr[ADDR_W:1] == addr_wr_data));

    assert_dual_is_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && rd_hi) |-> !mem_addr[0]);

    assert_no_idle_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_lo || rd_hi) |-> !mem_rd_en);
endmodule

// File: tb/test_vram_rd_port.sv
`timescale 1ns/1ps
module test_vram_rd_port;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_wr = 1'b0;
    logic [AW-1:0] addr_wr_data = '0;
    logic          ctrl_wr = 1'b0;
    logic [7:0]    ctrl_wr_data = '0;
    logic          rd_lo = 1'b0;
    logic          rd_hi = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          mem_rd_en;
    logic [AW:0]   mem_addr;
    logic [DW-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    vram_rd_port i_vram_rd_port (
        .clk(clk), .rst_n(rst_n),
        .addr_wr(addr_wr), .addr_wr_data(addr_wr_data),
        .ctrl_wr(ctrl_wr), .ctrl_wr_data(ctrl_wr_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [AW:0] a);
        return a[7:0] ^ {a[15:9], a[8]} ^ 8'hA5;
    endfunction

    // synchronous RAM model, one cycle latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [AW-1:0] m_addr = '0;
    logic [7:0]    m_buf = '0;
    logic          m_advhi = 1'b0;
    logic [1:0]    m_step = '0;

    function automatic logic [AW-1:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(32) : AW'(128);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one read cycle; starts and ends at a falling edge
    task automatic rd_cycle(input bit lo, input bit hi, input bit aw,
                            input logic [AW-1:0] awd, input string req);
        logic [AW-1:0] eff;
        logic          is_hi;
        logic [7:0]    ret;
        logic [AW:0]   baddr;
        eff   = aw ? awd : m_addr;
        is_hi = hi && !lo;
        baddr = {eff, is_hi};
        ret   = m_buf;
        m_buf = pat(baddr);
        m_addr = (is_hi == m_advhi) ? eff + step_of(m_step) : eff;
        rd_lo = lo; rd_hi = hi; addr_wr = aw; addr_wr_data = awd;
        #0.5;
        chk({req, " mem_rd_en"}, 32'(mem_rd_en), 32'd1);
        chk({req, " mem_addr"}, 32'(mem_addr), 32'(baddr));
        @(negedge clk);
        rd_lo = 0; rd_hi = 0; addr_wr = 0;
        chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " rd_data"}, 32'(rd_data), 32'(ret));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_addr(input logic [AW-1:0] a);
        addr_wr = 1; addr_wr_data = a;
        @(negedge clk);
        addr_wr = 0;
        m_addr = a;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1; ctrl_wr_data = v;
        @(negedge clk);
        ctrl_wr = 0;
        m_advhi = v[7];
        m_step = v[1:0];
    endtask

    task automatic t_reset;
        chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        chk("R11 mem_rd_en idle", 32'(mem_rd_en), 32'd0);
        rd_cycle(1, 0, 0, '0, "R1 first read");
        idle(1);
        chk("R11 rd_valid one cycle", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_low_seq;
        wr_ctrl(8'h00);
        wr_addr(15'h0123);
        for (int i = 0; i < 4; i++) begin
            rd_cycle(1, 0, 0, '0, "R2 low read step1");
            idle(2);
        end
        rd_cycle(0, 1, 0, '0, "R4 high no advance");
        rd_cycle(0, 1, 0, '0, "R3 high read");
    endtask

    task automatic t_high_adv;
        wr_ctrl(8'h80);
        wr_addr(15'h0400);
        for (int i = 0; i < 3; i++) begin
            rd_cycle(1, 0, 0, '0, "R4 low no advance");
            idle(1);
            rd_cycle(0, 1, 0, '0, "R3 high advance");
            idle(1);
        end
    endtask

    task automatic t_steps;
        for (int s = 1; s < 4; s++) begin
            wr_ctrl(8'(s));
            wr_addr(15'h1000);
            for (int i = 0; i < 3; i++) begin
                rd_cycle(1, 0, 0, '0, "R5 step encoding");
                idle(1);
            end
        end
    endtask

    task automatic t_wrap;
        wr_ctrl(8'h02);
        wr_addr(15'h7FC0);
        rd_cycle(1, 0, 0, '0, "R6 wrap start");
        rd_cycle(1, 0, 0, '0, "R6 wrapped by 128");
        chk("R6 model wrapped addr", 32'(m_addr), 32'h00C0);
        wr_ctrl(8'h00);
        wr_addr(15'h7FFF);
        rd_cycle(1, 0, 0, '0, "R6 wrap step1 start");
        rd_cycle(1, 0, 0, '0, "R6 wrapped to zero");
    endtask

    task automatic t_remap;
        wr_ctrl(8'h0D);
        wr_addr(15'h0200);
        rd_cycle(1, 0, 0, '0, "R7 remap bits set");
        rd_cycle(1, 0, 0, '0, "R7 remap step 32");
        wr_ctrl(8'h70);
        rd_cycle(1, 0, 0, '0, "R7 bits 6:4 ignored");
        rd_cycle(0, 1, 0, '0, "R7 bits 6:4 no adv on high");
        rd_cycle(1, 0, 0, '0, "R7 bits 6:4 step1");
    endtask

    task automatic t_same_cycle;
        wr_ctrl(8'h00);
        wr_addr(15'h0050);
        rd_cycle(1, 0, 1, 15'h2222, "R8 read with address write");
        rd_cycle(1, 0, 0, '0, "R8 advanced from new address");
        wr_ctrl(8'h80);
        rd_cycle(0, 1, 1, 15'h3333, "R8 high read with address write");
        rd_cycle(0, 1, 0, '0, "R8 high advanced");
    endtask

    task automatic t_dual;
        wr_ctrl(8'h80);
        wr_addr(15'h0777);
        rd_cycle(1, 1, 0, '0, "R10 both strobes is low read");
        rd_cycle(1, 1, 0, '0, "R10 low read no advance");
        rd_cycle(0, 1, 0, '0, "R10 high after dual");
    endtask

    task automatic t_b2b;
        wr_ctrl(8'h80);
        wr_addr(15'h0A00);
        for (int i = 0; i < 8; i++)
            rd_cycle(i % 2 == 0, i % 2 == 1, 0, '0, "R9 back-to-back");
        wr_ctrl(8'h01);
        for (int i = 0; i < 4; i++)
            rd_cycle(1, 0, 0, '0, "R9 back-to-back low step32");
        idle(1);
        chk("R11 rd_valid drops", 32'(rd_valid), 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_low_seq();
        t_high_adv();
        t_steps();
        t_wrap();
        t_remap();
        t_same_cycle();
        t_dual();
        t_b2b();
        idle(2);
        finish_run();
    end
endmodule